// File: doc/BRIEF.md
# AES-128 Block Encryptor with Chaining Register Port

The block is a byte-wide peripheral around an iterative AES-128 forward cipher. A host loads a 16-byte key and a 16-byte data block through a simple synchronous register port. It then writes a control byte with its request bit set and polls a completion flag. The ciphertext is read back from the same 16 bytes that held the input.

Two modes are offered. In single-block mode a written byte simply replaces the buffer byte. In chaining mode each written byte is combined by XOR with the byte already in the buffer, which after a run is the previous ciphertext. Running a message block by block in chaining mode builds a CBC chain, the basis of a message integrity code. The first block of a chain is run in single-block mode, with the host having already XORed it with the IV (zero for standard use).

The key is expanded one round at a time in the key buffer itself. After a run the key buffer therefore holds the tenth round key. Software saves that value as the inverse-cipher key, and must rewrite the original key before the next run. The control byte is also reachable at a second address placed right after the data buffer. A single incrementing burst can therefore carry the last data byte and the start request.

Top module: `aes_cbc_engine`

## Requirements
- R1: After reset the busy and done flags are 0, the control byte reads 0x00, and every key and data byte reads 0x00.
- R2: Key byte i is at address 0x40+i and data byte i at 0x84+i (i = 0..15, byte 0 first in the AES byte order). The control byte is at 0x83 and again at 0x94. A read returns data one cycle after the access, and an unmapped address reads 0x00.
- R3: Control byte layout: bits 2:1 mode, bit 3 direction (stored and read back; runs always encrypt), bit 4 busy (read-only), bit 0 done (read-only), bit 7 request (write-only, reads 0), bits 6:5 read 0.
- R4: A run encrypts the data buffer with the key buffer under AES-128. The FIPS-197 vector (key 000102..0f, input 00112233..ff) gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R5: When a request is accepted at clock edge E0, busy reads 1 on the next 10 reads sampled at edges E1..E10. At E11 busy reads 0 and done reads 1.
- R6: Done clears when a request is accepted and sets when the run ends. It then holds until the next accepted request.
- R7: A write with bit 7 set at 0x94, or at 0x83, stores the mode and direction bits and starts a run in that same access.
- R8: With mode 2 (chaining), each data-byte write stores the old byte XOR the written byte. A chained second block therefore encrypts plaintext XOR previous ciphertext.
- R9: Mode 0 and the reserved modes 1 and 3 behave as single-block mode: a data write replaces the byte.
- R10: After a run the key buffer reads the tenth round key. Rewriting the original key and encrypting any block yields that same value again.
- R11: While busy, writes to the key, the data buffer and the control byte are ignored, including a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid one cycle after a read |

## Verification
The checker watches the run handshake on every cycle. It confirms that busy lasts exactly ten cycles after an accepted request and never coexists with done. It also confirms that done rises only as busy falls, that busy starts only from a request write, and that the mode field is frozen during a run and follows an idle control write. Only the bench scenarios can show the cipher itself is right: the standard vector, the two-block chain against published CBC ciphertexts, the in-place XOR on write in chaining mode, the tenth-round key left in the key buffer, and that writes during a run leave both the result and the key untouched.

// File: rtl/aes_cbc_pkg.sv
package aes_cbc_pkg;

  localparam int BLK_BYTES  = 16;
  localparam int NUM_ROUNDS = 10;

  typedef logic [7:0] byte_t;
  typedef logic [BLK_BYTES-1:0][7:0] blk_t;

  localparam logic [1:0] MODE_CHAIN = 2'd2;

  function automatic byte_t xtime(byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gf_mul(byte_t a, byte_t b);
    byte_t p;
    byte_t x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xtime(x);
    end
    return p;
  endfunction

  // S-box from the multiplicative inverse (x^254) and the affine map
  function automatic byte_t sbox(byte_t x);
    byte_t s;
    byte_t r;
    s = x;
    r = 8'h01;
    for (int i = 0; i < 7; i++) begin
      s = gf_mul(s, s);
      r = gf_mul(r, s);
    end
    return r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]}
             ^ {r[3:0], r[7:4]} ^ 8'h63;
  endfunction

endpackage

// File: rtl/aes_round_logic.sv
module aes_round_logic
  import aes_cbc_pkg::*;
(
  input  blk_t st_in,
  input  blk_t rkey,
  input  logic last,
  output blk_t st_out
);
  blk_t sub_q;
  blk_t shf_q;
  blk_t mix_q;

  always_comb begin
    for (int i = 0; i < BLK_BYTES; i++) sub_q[i] = sbox(st_in[i]);
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        shf_q[r + 4*c] = sub_q[r + 4*((c + r) % 4)];
  end

  for (genvar c = 0; c < 4; c++) begin : g_col
    byte_t a0, a1, a2, a3;
    assign a0 = shf_q[4*c];
    assign a1 = shf_q[4*c+1];
    assign a2 = shf_q[4*c+2];
    assign a3 = shf_q[4*c+3];
    assign mix_q[4*c]   = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
    assign mix_q[4*c+1] = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
    assign mix_q[4*c+2] = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
    assign mix_q[4*c+3] = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);
  end

  assign st_out = (last ? shf_q : mix_q) ^ rkey;
endmodule

// File: rtl/aes_key_step.sv
module aes_key_step
  import aes_cbc_pkg::*;
(
  input  blk_t  key_in,
  input  byte_t rcon,
  output blk_t  key_out
);
  byte_t t [4];

  always_comb begin
    t[0] = sbox(key_in[13]) ^ rcon;
    t[1] = sbox(key_in[14]);
    t[2] = sbox(key_in[15]);
    t[3] = sbox(key_in[12]);
    for (int j = 0; j < 4; j++) begin
      key_out[j] = key_in[j] ^ t[j];
      for (int w = 1; w < 4; w++)
        key_out[4*w + j] = key_in[4*w + j] ^ key_out[4*(w-1) + j];
    end
  end
endmodule

// File: rtl/aes_cbc_engine.sv
module aes_cbc_engine
  import aes_cbc_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] KEY_BASE    = 'h40,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 'h83,
  parameter logic [ADDR_W-1:0] STATE_BASE  = 'h84,
  parameter logic [ADDR_W-1:0] MIRROR_ADDR = 'h94
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);
  localparam int RND_W = $clog2(NUM_ROUNDS + 1);
  localparam int IDX_W = $clog2(BLK_BYTES);

  blk_t             key_q, st_q, key_nx, st_nx;
  logic [1:0]       mode_q;
  logic             dir_q, busy_q, done_q;
  logic [RND_W-1:0] rnd_q;
  byte_t            rcon_q;
  logic [7:0]       rdata_q;

  logic [ADDR_W-1:0] key_off, st_off;
  logic              hit_key, hit_st, hit_ctl, wr_ok, start;
  logic [IDX_W-1:0]  key_idx, st_idx;

  assign key_off = bus_addr - KEY_BASE;
  assign st_off  = bus_addr - STATE_BASE;
  assign hit_key = key_off < ADDR_W'(BLK_BYTES);
  assign hit_st  = st_off  < ADDR_W'(BLK_BYTES);
  assign hit_ctl = (bus_addr == CTRL_ADDR) || (bus_addr == MIRROR_ADDR);
  assign key_idx = key_off[IDX_W-1:0];
  assign st_idx  = st_off[IDX_W-1:0];
  assign wr_ok   = bus_sel && bus_we && !busy_q;
  assign start   = wr_ok && hit_ctl && bus_wdata[7];

  aes_key_step u_key (
    .key_in (key_q),
    .rcon   (rcon_q),
    .key_out(key_nx)
  );

  aes_round_logic u_rnd (
    .st_in (st_q),
    .rkey  (key_nx),
    .last  (rnd_q == RND_W'(NUM_ROUNDS)),
    .st_out(st_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q  <= '0;
      st_q   <= '0;
      mode_q <= '0;
      dir_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rnd_q  <= '0;
      rcon_q <= 8'h01;
    end else if (busy_q) begin
      st_q   <= st_nx;
      key_q  <= key_nx;
      rcon_q <= xtime(rcon_q);
      rnd_q  <= rnd_q + 1'b1;
      if (rnd_q == RND_W'(NUM_ROUNDS)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else if (wr_ok) begin
      if (hit_key) key_q[key_idx] <= bus_wdata;
      if (hit_st)
        st_q[st_idx] <= (mode_q == MODE_CHAIN) ? (st_q[st_idx] ^ bus_wdata)
                                                : bus_wdata;
      if (hit_ctl) begin
        mode_q <= bus_wdata[2:1];
        dir_q  <= bus_wdata[3];
      end
      if (start) begin
        st_q   <= st_q ^ key_q;   // initial round-key addition
        busy_q <= 1'b1;
        done_q <= 1'b0;
        rnd_q  <= RND_W'(1);
        rcon_q <= 8'h01;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_sel && !bus_we) begin
      if (hit_key)      rdata_q <= key_q[key_idx];
      else if (hit_st)  rdata_q <= st_q[st_idx];
      else if (hit_ctl) rdata_q <= {3'b000, busy_q, dir_q, mode_q, done_q};
      else              rdata_q <= '0;
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/aes_cbc_engine_chk.sv
module aes_cbc_engine_chk #(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 'h83,
  parameter logic [ADDR_W-1:0] MIRROR_ADDR = 'h94,
  parameter int                ROUNDS      = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              busy,
  input logic              done,
  input logic [1:0]        mode
);
  logic       ctl_wr, req_wr;
  logic [4:0] run_cnt;

  assign ctl_wr = bus_sel && bus_we &&
                  ((bus_addr == CTRL_ADDR) || (bus_addr == MIRROR_ADDR));
  assign req_wr = ctl_wr && bus_wdata[7];

  always_ff @(posedge clk) begin
    if (rst)                  run_cnt <= '0;
    else if (req_wr && !busy) run_cnt <= '0;
    else if (busy)            run_cnt <= run_cnt + 1'b1;
  end

  a_r5_run_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> run_cnt == 5'(ROUNDS));

  a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);

  a_r6_done_at_end: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $fell(busy));

  a_r7_start_from_request: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_wr));

  a_r11_mode_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(mode));

  a_r3_mode_written: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !busy) |=> mode == $past(bus_wdata[2:1]));
endmodule

bind aes_cbc_engine aes_cbc_engine_chk #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .MIRROR_ADDR(MIRROR_ADDR),
  .ROUNDS(aes_cbc_pkg::NUM_ROUNDS)
) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .busy(busy_q), .done(done_q), .mode(mode_q)
);

// File: tb/aes_cbc_engine_test.sv
module aes_cbc_engine_test;
  localparam int CLK_PERIOD = 10;

  localparam logic [7:0] A_KEY = 8'h40;
  localparam logic [7:0] A_CTL = 8'h83;
  localparam logic [7:0] A_ST  = 8'h84;
  localparam logic [7:0] A_MIR = 8'h94;

  localparam logic [127:0] FIPS_KEY = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] FIPS_PT  = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] FIPS_CT  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] FIPS_RK  = 128'h13111d7fe3944a17f307a78b4d2b30c5;
  localparam logic [127:0] CH_KEY   = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] CH_IV    = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] CH_P1    = 128'h6bc1bee22e409f96e93d7e117393172a;
  localparam logic [127:0] CH_P2    = 128'hae2d8a571e03ac9c9eb76fac45af8e51;
  localparam logic [127:0] CH_C1    = 128'h7649abac8119b246cee98e9b12e9197d;
  localparam logic [127:0] CH_C2    = 128'h5086cb9b507219ee95db113a917678b2;
  localparam logic [127:0] CH_RK    = 128'hd014f9a8c9ee2589e13f0cc8b6630ca6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aes_cbc_engine uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // each bus task is entered at a falling edge and returns at the next one
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wr16(input logic [7:0] base, input logic [127:0] v);
    for (int i = 0; i < 16; i++) wr(base + 8'(i), v[127-8*i -: 8]);
  endtask

  task automatic rd16(input logic [7:0] base, output logic [127:0] v);
    logic [7:0] b;
    for (int i = 0; i < 16; i++) begin
      rd(base + 8'(i), b);
      v[127-8*i -: 8] = b;
    end
  endtask

  task automatic wait_done();
    logic [7:0] c;
    for (int k = 0; k < 40; k++) begin
      rd(A_CTL, c);
      if (c[0]) return;
    end
    chk("R6 done never set", {120'd0, c}, 128'h01);
  endtask

  // request through the mirror address and time the run (R5, R6, R7)
  task automatic run_timed(input logic [7:0] ctl);
    logic [7:0] c;
    wr(A_MIR, ctl);
    for (int k = 1; k <= 11; k++) begin
      rd(A_CTL, c);
      if (k == 1)  chk("R6 R7 busy set, done cleared", {120'd0, c[4], c[0]}, 128'h2);
      if (k == 10) chk("R5 still busy at 10th read", {127'd0, c[4]}, 128'h1);
      if (k == 11) chk("R5 R6 done at 11th read", {120'd0, c[4], c[0]}, 128'h1);
    end
  endtask

  task automatic t_reset();
    logic [127:0] v;
    logic [7:0] c;
    rd(A_CTL, c);
    chk("R1 control after reset", {120'd0, c}, 128'h0);
    rd16(A_ST, v);
    chk("R1 data after reset", v, 128'h0);
    rd16(A_KEY, v);
    chk("R1 key after reset", v, 128'h0);
  endtask

  task automatic t_fips();
    logic [127:0] v;
    logic [7:0] c;
    wr16(A_KEY, FIPS_KEY);
    wr(A_CTL, 8'h00);
    wr16(A_ST, FIPS_PT);
    run_timed(8'h80);
    rd16(A_ST, v);
    chk("R4 standard vector", v, FIPS_CT);
    rd16(A_KEY, v);
    chk("R10 key buffer holds round-10 key", v, FIPS_RK);
    rd(A_CTL, c);
    chk("R6 done holds after run", {120'd0, c}, 128'h01);
  endtask

  task automatic t_chain();
    logic [127:0] v;
    wr16(A_KEY, CH_KEY);
    wr(A_CTL, 8'h00);
    wr16(A_ST, CH_P1 ^ CH_IV);
    run_timed(8'h80);
    rd16(A_ST, v);
    chk("R4 R7 first chain block", v, CH_C1);
    rd16(A_KEY, v);
    chk("R10 round-10 key of chain key", v, CH_RK);
    wr16(A_KEY, CH_KEY);
    wr(A_CTL, 8'h04);                // mode 2
    wr16(A_ST, CH_P2);
    rd16(A_ST, v);
    chk("R8 write XORs with held ciphertext", v, CH_P2 ^ CH_C1);
    wr(A_MIR, 8'h84);
    wait_done();
    rd16(A_ST, v);
    chk("R8 second chain block", v, CH_C2);
  endtask

  task automatic t_modes();
    logic [127:0] v;
    logic [7:0] c;
    wr(A_CTL, 8'h06);                // reserved mode 3
    wr16(A_ST, CH_P1);
    rd16(A_ST, v);
    chk("R9 reserved mode 3 replaces bytes", v, CH_P1);
    wr(A_CTL, 8'h02);                // reserved mode 1
    wr16(A_ST, FIPS_PT);
    rd16(A_ST, v);
    chk("R9 reserved mode 1 replaces bytes", v, FIPS_PT);
    wr(A_CTL, 8'h0c);
    rd(A_CTL, c);
    chk("R3 direction and mode read back", {120'd0, c}, 128'h0d);
    rd(8'h00, c);
    chk("R2 unmapped read", {120'd0, c}, 128'h0);
    rd(8'h95, c);
    chk("R2 unmapped read past mirror", {120'd0, c}, 128'h0);
  endtask

  // key recovery by dummy run, plus writes during a run (R10, R11)
  task automatic t_busy();
    logic [127:0] v;
    logic [7:0] c;
    wr16(A_KEY, FIPS_KEY);
    wr(A_CTL, 8'h00);
    wr16(A_ST, FIPS_PT);
    wr(A_MIR, 8'h80);
    wr(A_ST, 8'hff);
    wr(A_KEY + 8'd5, 8'hff);
    wr(A_CTL, 8'h84);                // request while busy
    wait_done();
    rd16(A_ST, v);
    chk("R11 data writes while busy ignored", v, FIPS_CT);
    rd16(A_KEY, v);
    chk("R10 R11 key recovered, key write ignored", v, FIPS_RK);
    rd(A_CTL, c);
    chk("R11 control write while busy ignored", {120'd0, c}, 128'h01);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fips();
    t_chain();
    t_modes();
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule